// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is the tag side of a single-level, write-back cache with N ways per set and true least-recently-used replacement. It keeps no data. For every line it stores a tag, a valid flag and a dirty flag, and for every set it keeps a recency order of the ways. A requester presents one access at a time: a physical address and a kind (read, write or instruction fetch). One cycle later the block reports whether the access hit. On a miss it also reports whether the replaced line was dirty and had to be written back, and gives that line's tag.

Running counters record the totals needed to judge a configuration: accesses, hits, misses, write-backs, and read and write totals each with their own miss counts. Line size, total capacity and way count are elaboration parameters, and all of them are powers of two. The offset, index and tag fields of the address follow from those parameters.

Top module: `cache_tag_dir`

## Requirements
- R1: The low log2(LINE_BYTES) address bits are the offset and do not affect the lookup. The next log2(SETS) bits select the set, where SETS = CACHE_BYTES / (LINE_BYTES × WAYS). The remaining upper bits of the 32-bit address form the tag.
- R2: After reset every line is invalid, every counter reads zero, `req_ready` is high and `rsp_valid` is low. The first reference to any line therefore misses.
- R3: An access hits exactly when its set holds a valid line with an equal tag. A run of accesses to one line gives one miss followed by hits only.
- R4: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the following cycle, and `req_ready` is low during that cycle. A request held high while `req_ready` is low is not accepted on that edge.
- R5: A miss never replaces a valid line while its set still has an invalid way.
- R6: Every hit and every fill makes the touched line the most recent in its set. When all ways are valid, a miss replaces the least recently referenced line.
- R7: A write sets the line's dirty flag, whether it hits or fills. A miss that replaces a valid dirty line raises `rsp_wb`, puts that line's tag on `rsp_victim_tag` and increments `cnt_wb`. Any other access reports `rsp_wb` = 0 and `rsp_victim_tag` = 0.
- R8: The `req_kind` encoding is 2'b00 read, 2'b01 write, 2'b10 instruction fetch and 2'b11 read. Every kind other than 2'b01 behaves as a read and is counted as one.
- R9: Each accepted access increments `cnt_access`, and also exactly one of `cnt_hit` and `cnt_miss`. Reads increment `cnt_read`, writes increment `cnt_write`, and `cnt_read_miss` and `cnt_write_miss` count the misses of each kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | Access kind (see R8) |
| req_addr | input | ADDR_W | Physical byte address |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Result of the previous accepted access |
| rsp_hit | output | 1 | That access hit |
| rsp_wb | output | 1 | A dirty line was replaced |
| rsp_victim_tag | output | TAG_W | Tag of the written-back line, else zero |
| cnt_access | output | CNT_W | Accepted accesses |
| cnt_hit | output | CNT_W | Hits |
| cnt_miss | output | CNT_W | Misses |
| cnt_wb | output | CNT_W | Write-backs |
| cnt_read | output | CNT_W | Read and fetch accesses |
| cnt_read_miss | output | CNT_W | Read and fetch misses |
| cnt_write | output | CNT_W | Write accesses |
| cnt_write_miss | output | CNT_W | Write misses |

## Verification
The first directed pattern repeats one line with changing offsets. It separates a correct field split from one that lets offset bits reach the tag. A second pattern fills one set past its way count in a fixed order, with a re-touch and a write mixed in. It separates a true recency order from one that is not promoted on a hit, and a clean replacement from a dirty one. The run ends with a long sweep of mixed kinds over few tags and sets, compared against an age-stamp model in the bench. That sweep exposes errors in the recency order, the dirty flags and the counters that the short patterns do not reach.

// File: rtl/ctd_pkg.sv
// Shared types for the cache tag directory.
// Assumes: the access kind fits two bits; only the write code marks a line dirty.
package ctd_pkg;
    typedef enum logic [1:0] {
        ACC_READ   = 2'b00,
        ACC_WRITE  = 2'b01,
        ACC_IFETCH = 2'b10,
        ACC_OTHER  = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/ctd_way_store.sv
// One way of the directory: a tag, a valid flag and a dirty flag for every set.
// Reads are combinational at rd_idx. A write refreshes all three fields of one set.
// Assumes: the caller writes only on an accepted access; tags need no reset.
module ctd_way_store #(
    parameter int SETS  = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    logic [TAG_W-1:0] tag_q   [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    // Tag storage: written on fill or hit, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[rd_idx] <= wr_tag;
    end

    // Flag storage: cleared by reset so the cache starts cold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[rd_idx] <= 1'b1;
            dirty_q[rd_idx] <= wr_dirty;
        end
    end

    // Read port at the current index.
    always_comb begin
        rd_tag   = tag_q[rd_idx];
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
    end
endmodule

// File: rtl/ctd_lru.sv
// Recency order of each set, kept as one rank per way: 0 is the most recent
// and WAYS-1 the least recent. Touching a way gives it rank 0. Every way that
// ranked above it moves down by one rank.
// Assumes: WAYS is a power of two; the ranks of a set always form a permutation.
module ctd_lru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int IDX_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [WAY_W-1:0] lru_way,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);
    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic [WAY_W-1:0] old_rank;

    // Find the least recent way of the addressed set.
    always_comb begin
        lru_way  = '0;
        old_rank = rank_q[idx][touch_way];
        for (int w = 0; w < WAYS; w++) begin
            if (rank_q[idx][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
        end
    end

    // Reset to an identity order; promote the touched way on each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[idx][w] <= '0;
                else if (rank_q[idx][w] < old_rank)
                    rank_q[idx][w] <= rank_q[idx][w] + WAY_W'(1);
            end
        end
    end

    // Per-set check that the ranks remain a permutation of 0..WAYS-1.
    for (genvar s = 0; s < SETS; s++) begin : g_perm
        logic [WAYS-1:0] seen;
        // Mark every rank present in set s.
        always_comb begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) seen[rank_q[s][w]] = 1'b1;
        end
        AST_LRU_PERM: assert property (@(posedge clk) disable iff (!rst_n)
            &seen); // R6
    end
endmodule

// File: rtl/ctd_stats.sv
// Event counters for the directory, each advanced by one accepted access.
// Assumes: ev_valid is high for at most one cycle per access; the counters wrap.
module ctd_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_hit,
    input  logic             ev_wb,
    input  logic             ev_write,
    output logic [CNT_W-1:0] cnt_access,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_miss,
    output logic [CNT_W-1:0] cnt_wb,
    output logic [CNT_W-1:0] cnt_read,
    output logic [CNT_W-1:0] cnt_read_miss,
    output logic [CNT_W-1:0] cnt_write,
    output logic [CNT_W-1:0] cnt_write_miss
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance the counters that match the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_access     <= '0;
            cnt_hit        <= '0;
            cnt_miss       <= '0;
            cnt_wb         <= '0;
            cnt_read       <= '0;
            cnt_read_miss  <= '0;
            cnt_write      <= '0;
            cnt_write_miss <= '0;
        end else if (ev_valid) begin
            cnt_access <= cnt_access + ONE;
            if (ev_hit) cnt_hit  <= cnt_hit + ONE;
            else        cnt_miss <= cnt_miss + ONE;
            if (ev_wb)  cnt_wb   <= cnt_wb + ONE;
            if (ev_write) begin
                cnt_write <= cnt_write + ONE;
                if (!ev_hit) cnt_write_miss <= cnt_write_miss + ONE;
            end else begin
                cnt_read <= cnt_read + ONE;
                if (!ev_hit) cnt_read_miss <= cnt_read_miss + ONE;
            end
        end
    end

    AST_HIT_MISS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit + cnt_miss == cnt_access); // R9
    AST_KIND_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_read + cnt_write == cnt_access); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> cnt_access == $past(cnt_access) + ONE); // R9
endmodule

// File: rtl/cache_tag_dir.sv
// Tag directory of a write-back set-associative cache with true LRU replacement.
// A lookup is accepted when req_valid and req_ready are both high. At the same
// edge the tags, the recency order and the counters are updated and the result
// is registered, so it appears on rsp_* during the next cycle. No request is
// accepted in that cycle.
// Assumes: all size parameters are powers of two and give at least two sets.
module cache_tag_dir
    import ctd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 16,
    parameter int CACHE_BYTES = 256,
    parameter int WAYS        = 4,
    parameter int CNT_W       = 32,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int SETS       = CACHE_BYTES / (LINE_BYTES * WAYS),
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_wb,
    output logic [TAG_W-1:0]  rsp_victim_tag,
    output logic [CNT_W-1:0]  cnt_access,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_wb,
    output logic [CNT_W-1:0]  cnt_read,
    output logic [CNT_W-1:0]  cnt_read_miss,
    output logic [CNT_W-1:0]  cnt_write,
    output logic [CNT_W-1:0]  cnt_write_miss
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             unused_offset_bits;
    logic             accept;
    logic             is_write;

    logic [TAG_W-1:0] way_tag [WAYS];
    logic [WAYS-1:0]  way_valid;
    logic [WAYS-1:0]  way_dirty;
    logic [WAYS-1:0]  hit_vec;
    logic [WAYS-1:0]  wr_en;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             has_inv;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] victim_way;
    logic [WAY_W-1:0] touch_way;
    logic             wb;
    logic             new_dirty;

    logic             rsp_valid_q;
    logic             rsp_hit_q;
    logic             rsp_wb_q;
    logic [TAG_W-1:0] rsp_victim_q;

    // Address split and request acceptance.
    assign idx                = req_addr[OFF_W +: IDX_W];
    assign tag                = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset_bits = ^req_addr[OFF_W-1:0];
    assign req_ready          = !rsp_valid_q;
    assign accept             = req_valid && req_ready;
    assign is_write           = (req_kind == ACC_WRITE);

    // One storage slice per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ctd_way_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (idx),
            .rd_tag   (way_tag[w]),
            .rd_valid (way_valid[w]),
            .rd_dirty (way_dirty[w]),
            .wr_en    (wr_en[w]),
            .wr_tag   (tag),
            .wr_dirty (new_dirty)
        );
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == tag);
        assign wr_en[w]   = accept && (touch_way == WAY_W'(w));
    end

    ctd_lru #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .lru_way   (lru_way),
        .touch_en  (accept),
        .touch_way (touch_way)
    );

    // Encode the hitting way and the lowest invalid way.
    always_comb begin
        hit_way = '0;
        inv_way = '0;
        has_inv = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
            if (!way_valid[w]) begin
                inv_way = WAY_W'(w);
                has_inv = 1'b1;
            end
        end
    end

    // Choose the line to touch and decide the write-back and the new dirty flag.
    always_comb begin
        hit        = |hit_vec;
        victim_way = has_inv ? inv_way : lru_way;
        touch_way  = hit ? hit_way : victim_way;
        wb         = !hit && way_valid[victim_way] && way_dirty[victim_way];
        new_dirty  = hit ? (way_dirty[hit_way] || is_write) : is_write;
    end

    // Register the response of an accepted access for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q  <= 1'b0;
            rsp_hit_q    <= 1'b0;
            rsp_wb_q     <= 1'b0;
            rsp_victim_q <= '0;
        end else begin
            rsp_valid_q <= accept;
            if (accept) begin
                rsp_hit_q    <= hit;
                rsp_wb_q     <= wb;
                rsp_victim_q <= wb ? way_tag[victim_way] : '0;
            end
        end
    end

    assign rsp_valid      = rsp_valid_q;
    assign rsp_hit        = rsp_hit_q;
    assign rsp_wb         = rsp_wb_q;
    assign rsp_victim_tag = rsp_victim_q;

    ctd_stats #(.CNT_W(CNT_W)) u_stats (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_valid       (accept),
        .ev_hit         (hit),
        .ev_wb          (wb),
        .ev_write       (is_write),
        .cnt_access     (cnt_access),
        .cnt_hit        (cnt_hit),
        .cnt_miss       (cnt_miss),
        .cnt_wb         (cnt_wb),
        .cnt_read       (cnt_read),
        .cnt_read_miss  (cnt_read_miss),
        .cnt_write      (cnt_write),
        .cnt_write_miss (cnt_write_miss)
    );

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4
    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $onehot0(hit_vec)); // R3
    AST_WB_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_wb |-> !rsp_hit); // R7
    AST_WB_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_wb |-> cnt_wb == $past(cnt_wb) + CNT_W'(1)); // R7
    AST_FILL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !hit && has_inv |-> !way_valid[touch_way]); // R5
endmodule

// File: tb/sim_cache_tag_dir.sv
// Bench for cache_tag_dir at 16-byte lines, 256 bytes and 4 ways, which gives
// 4 sets. Address layout: bits [3:0] are the offset, bits [5:4] the set and
// bits [31:6] the tag.
module sim_cache_tag_dir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_wb;
    logic [25:0] rsp_victim_tag;
    logic [31:0] cnt_access, cnt_hit, cnt_miss, cnt_wb;
    logic [31:0] cnt_read, cnt_read_miss, cnt_write, cnt_write_miss;

    always #5 clk = ~clk;

    cache_tag_dir u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_wb(rsp_wb), .rsp_victim_tag(rsp_victim_tag),
        .cnt_access(cnt_access), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss),
        .cnt_wb(cnt_wb), .cnt_read(cnt_read), .cnt_read_miss(cnt_read_miss),
        .cnt_write(cnt_write), .cnt_write_miss(cnt_write_miss)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Age-stamp model of the directory.
    bit          m_v [4][4];
    bit          m_d [4][4];
    int unsigned m_t [4][4];
    longint      m_s [4][4];
    longint      now;
    int unsigned e_acc, e_hit, e_miss, e_wb, e_rd, e_rdm, e_wr, e_wrm;
    bit          got_hit, got_wb;
    int unsigned got_vtag;

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int unsigned t, input int unsigned s, input int unsigned o);
        return (t << 6) | ((s & 3) << 4) | (o & 15);
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; m_s[s][w] = 0;
            end
        now = 1;
        e_acc = 0; e_hit = 0; e_miss = 0; e_wb = 0;
        e_rd = 0; e_rdm = 0; e_wr = 0; e_wrm = 0;
    endtask

    task automatic model_acc(input logic [1:0] k, input logic [31:0] a,
                             output bit eh, output bit ewb, output int unsigned evt);
        int s = int'(a[5:4]);
        int unsigned t = a >> 6;
        bit wr = (k == 2'b01);
        int pick = -1;
        eh = 0; ewb = 0; evt = 0;
        for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == t) pick = w;
        if (pick >= 0) begin
            eh = 1;
            m_d[s][pick] = m_d[s][pick] | wr;
        end else begin
            for (int w = 3; w >= 0; w--) if (!m_v[s][w]) pick = w;
            if (pick < 0) begin
                pick = 0;
                for (int w = 1; w < 4; w++) if (m_s[s][w] < m_s[s][pick]) pick = w;
            end
            ewb = m_v[s][pick] && m_d[s][pick];
            evt = ewb ? m_t[s][pick] : 0;
            m_v[s][pick] = 1; m_t[s][pick] = t; m_d[s][pick] = wr;
        end
        m_s[s][pick] = now;
        now++;
        e_acc++;
        if (eh) e_hit++; else e_miss++;
        if (ewb) e_wb++;
        if (wr) begin e_wr++; if (!eh) e_wrm++; end
        else begin e_rd++; if (!eh) e_rdm++; end
    endtask

    // One access: drive at a falling edge, sample one cycle after acceptance.
    task automatic do_acc(input logic [1:0] k, input logic [31:0] a);
        bit eh, ewb;
        int unsigned evt;
        model_acc(k, a, eh, ewb, evt);
        req_valid = 1'b1; req_kind = k; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        got_hit = rsp_hit; got_wb = rsp_wb; got_vtag = rsp_victim_tag;
        chk("R4 rsp_valid after accept", rsp_valid, 1);
        chk("R4 ready low while pending", req_ready, 0);
        chk("R3 hit", rsp_hit, eh);
        chk("R7 wb", rsp_wb, ewb);
        chk("R7 victim tag", rsp_victim_tag, evt);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_counters(input string tag);
        chk({"R9 access ", tag}, cnt_access, e_acc);
        chk({"R9 hit ", tag}, cnt_hit, e_hit);
        chk({"R9 miss ", tag}, cnt_miss, e_miss);
        chk({"R7 wb count ", tag}, cnt_wb, e_wb);
        chk({"R9 read ", tag}, cnt_read, e_rd);
        chk({"R9 read miss ", tag}, cnt_read_miss, e_rdm);
        chk({"R9 write ", tag}, cnt_write, e_wr);
        chk({"R9 write miss ", tag}, cnt_write_miss, e_wrm);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned c1, rd0;
        bit eh, ewb;
        int unsigned evt;
        do_reset();

        // R2: cold reset state at the ports.
        chk("R2 ready after reset", req_ready, 1);
        chk("R2 rsp_valid after reset", rsp_valid, 0);
        chk_counters("after reset");

        // R1/R3: one line, different offsets: one miss then hits only.
        for (int i = 0; i < 20; i++) begin
            do_acc(2'b00, mk(5, 1, i));
            chk(i == 0 ? "R3 first ref misses" : "R1 offset ignored, hit", got_hit, i != 0);
        end
        chk("R3 single miss", cnt_miss, 1);
        chk("R3 nineteen hits", cnt_hit, 19);

        // R5: fill set 2 with four tags; none of them is lost.
        for (int t = 1; t <= 4; t++) do_acc(2'b00, mk(t, 2, 0));
        for (int t = 1; t <= 4; t++) begin
            do_acc(2'b00, mk(t, 2, 8));
            chk("R5 no valid line replaced while ways free", got_hit, 1);
        end

        // R6/R7: order 4,3,2,1 -> touch 1 -> write 3 -> tag 9 replaces clean 2.
        do_acc(2'b00, mk(1, 2, 0));
        do_acc(2'b01, mk(3, 2, 0));
        chk("R7 write hit no wb", got_wb, 0);
        do_acc(2'b00, mk(9, 2, 0));
        chk("R6 tag 9 misses", got_hit, 0);
        chk("R7 clean victim no wb", got_wb, 0);
        chk("R7 clean victim tag zero", got_vtag, 0);
        do_acc(2'b00, mk(2, 2, 0));
        chk("R6 least recent tag 2 was replaced", got_hit, 0);
        do_acc(2'b00, mk(10, 2, 0));   // replaces 1
        do_acc(2'b00, mk(11, 2, 0));   // replaces dirty 3
        chk("R7 dirty victim wb", got_wb, 1);
        chk("R7 dirty victim tag", got_vtag, 3);
        do_acc(2'b00, mk(4, 2, 0));
        chk("R6 tag 4 replaced before 9", got_hit, 0);

        // R8: fetch and code 3 count as reads; a write miss sets the dirty flag.
        rd0 = cnt_read;
        do_acc(2'b10, mk(20, 3, 0));
        do_acc(2'b11, mk(20, 3, 4));
        chk("R8 fetch and code 3 counted as reads", cnt_read - rd0, 2);
        chk("R8 code 3 hits the fetched line", got_hit, 1);
        do_acc(2'b01, mk(40, 0, 0));
        for (int t = 41; t <= 44; t++) do_acc(2'b00, mk(t, 0, 0));
        chk("R7 write-miss fill made line dirty", got_wb, 1);
        chk("R7 write-miss victim tag", got_vtag, 40);
        chk_counters("directed");

        // R4: a request held high while ready is low is not taken on that edge.
        model_acc(2'b00, mk(50, 1, 0), eh, ewb, evt);
        req_valid = 1'b1; req_kind = 2'b00; req_addr = mk(50, 1, 0);
        @(posedge clk); @(negedge clk);
        c1 = cnt_access;
        req_addr = mk(51, 1, 0);
        @(negedge clk);
        chk("R4 held request not accepted while busy", cnt_access, c1);
        chk("R4 ready back after response", req_ready, 1);
        model_acc(2'b00, mk(51, 1, 0), eh, ewb, evt);
        @(negedge clk);
        chk("R4 held request accepted once ready", cnt_access, c1 + 1);
        chk("R4 response for held request", rsp_valid, 1);
        req_valid = 1'b0;
        @(negedge clk);

        // R2: a second reset empties the directory again.
        do_reset();
        chk_counters("after second reset");
        do_acc(2'b00, mk(5, 1, 0));
        chk("R2 line misses after reset", got_hit, 0);

        // Mixed sweep over few tags, checked access by access against the model.
        void'($urandom(7));
        for (int i = 0; i < 1500; i++) begin
            do_acc(2'($urandom_range(3)), mk($urandom_range(7), $urandom_range(3), $urandom_range(15)));
        end
        chk_counters("sweep");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule